// File: doc/BRIEF.md
# Software Write-Protect Command Sequencer

This block sits between the write-strobe pins of a byte-wide nonvolatile memory and its page buffer. It watches each completed write strobe, together with the address and data captured while the strobe was active, and recognises fixed address/data unlock sequences. A three-write preamble arms protection. The same preamble, when the array is already protected, also admits one protected page load. A six-write sequence arms the release of protection. The bytes that make up these sequences never reach the page buffer.

Every accepted write opens or restarts a page-load window. When the window closes, the block asks an external programming timer to start, and it ignores all strobes until that timer reports completion. A pending change of protection state takes effect only at that completion. While protected, a write without the preamble still starts the timer, but nothing is loaded. Writes are also blocked by hardware conditions: the supply is reported low, the power-on settling delay has not yet run out, or the strobe pulse was too short. The protection flag is not cleared by the ordinary reset. Only a dedicated factory-initialisation input clears it.

Top module: `wp_cmd_seq`

## Requirements
- R1: The preamble is three consecutive accepted writes: data 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. Only the low 15 address bits and the low 8 data bits are compared. None of these writes asserts `load_en`.
- R2: The release sequence is six consecutive accepted writes: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. None of them asserts `load_en`.
- R3: An ordinary accepted write asserts `load_en` for exactly one cycle, on the edge that samples the strobe low, with the captured address and data. This happens when `wp_on` is 0, or when the write follows a completed preamble or release sequence in the same load window.
- R4: While `wp_on` is 1, an ordinary write with no preamble does not assert `load_en`. It still opens the load window, so `prog_req` follows.
- R5: After a completed preamble, `wp_on` rises on the edge that samples `prog_done` at the end of the next programming period, even when no data was loaded. It does not rise earlier.
- R6: After a completed release sequence, `wp_on` falls on the edge that samples `prog_done` at the end of the next programming period, even when no data was loaded.
- R7: `prog_req` is a one-cycle pulse asserted LOAD_WIN+1 clock edges after the edge of the last accepted write. Each accepted write restarts this count.
- R8: No write is accepted while `supply_ok` is 0, or within PON_CYCLES cycles after `supply_ok` rises.
- R9: A strobe that is high for fewer than MIN_PULSE sampled cycles is ignored.
- R10: Strobes are ignored from `prog_req` until `prog_done`. Such strobes start no load window.
- R11: A write that does not match the expected next step returns the sequencer to its first step, and that write is handled as an ordinary write.
- R12: `rst_n` does not change `wp_on`. `factory_init` clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset (sequencer state only) |
| factory_init | input | 1 | Clears the protection flag |
| supply_ok | input | 1 | Qualified supply-above-threshold indication |
| wr_stb | input | 1 | Write strobe, active high, held for the pulse duration |
| wr_addr | input | ADDR_W | Write address, captured while the strobe is high |
| wr_data | input | DATA_W | Write data, captured while the strobe is high |
| prog_done | input | 1 | Programming timer finished |
| wp_on | output | 1 | Protection active |
| load_en | output | 1 | Commit the captured byte to the page buffer |
| load_addr | output | ADDR_W | Address for the committed byte |
| load_data | output | DATA_W | Data for the committed byte |
| prog_req | output | 1 | Start the programming timer |

## Verification
The bench builds the block with MIN_PULSE=3, LOAD_WIN=12 and PON_CYCLES=24. These small values mean the power-on hold-off, the window expiry and the short-pulse boundary (a 2-cycle pulse rejected, a 3-cycle pulse accepted) all occur within a few dozen cycles. The short window lets every scenario run through a complete programming period. That includes periods that carry no data, enable-only and release-only, and the busy gap in which strobes must be dropped.

// File: rtl/wp_cmd_seq.sv
module wp_cmd_seq #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int MIN_PULSE  = 3,
  parameter int LOAD_WIN   = 37500,
  parameter int PON_CYCLES = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              factory_init,
  input  logic              supply_ok,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_done,
  output logic              wp_on,
  output logic              load_en,
  output logic [ADDR_W-1:0] load_addr,
  output logic [DATA_W-1:0] load_data,
  output logic              prog_req
);
  localparam int PW = $clog2(MIN_PULSE + 1);
  localparam int WW = $clog2(LOAD_WIN + 1);
  localparam int NW = $clog2(PON_CYCLES + 1);
  localparam logic [14:0] ADR_HI = 15'h5555;
  localparam logic [14:0] ADR_LO = 15'h2AAA;

  typedef enum logic [2:0] {ST_IDLE, ST_K1, ST_K2, ST_R3, ST_R4, ST_R5} step_t;
  typedef enum logic [1:0] {PD_NONE, PD_ON, PD_OFF} pend_t;

  step_t             step, step_nx;
  pend_t             pend;
  logic              stb_q, busy, win_act, unlock;
  logic [PW-1:0]     hi_cnt;
  logic [WW-1:0]     win_cnt;
  logic [NW-1:0]     pon_cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              cmd, arm_on, arm_off;

  wire        ev   = stb_q && !wr_stb && (hi_cnt >= PW'(MIN_PULSE)) &&
                     supply_ok && (pon_cnt == '0) && !busy;
  wire [14:0] a15  = addr_q[14:0];
  wire [7:0]  d8   = data_q[7:0];
  wire        k_aa = (a15 == ADR_HI) && (d8 == 8'hAA);
  wire        k_55 = (a15 == ADR_LO) && (d8 == 8'h55);
  wire        k_a0 = (a15 == ADR_HI) && (d8 == 8'hA0);
  wire        k_80 = (a15 == ADR_HI) && (d8 == 8'h80);
  wire        k_20 = (a15 == ADR_HI) && (d8 == 8'h20);

  always_comb begin
    step_nx = ST_IDLE;
    cmd     = 1'b0;
    arm_on  = 1'b0;
    arm_off = 1'b0;
    unique case (step)
      ST_IDLE: if (k_aa) begin step_nx = ST_K1; cmd = 1'b1; end
      ST_K1:   if (k_55) begin step_nx = ST_K2; cmd = 1'b1; end
      ST_K2:   if (k_a0) begin cmd = 1'b1; arm_on = 1'b1; end
               else if (k_80) begin step_nx = ST_R3; cmd = 1'b1; end
      ST_R3:   if (k_aa) begin step_nx = ST_R4; cmd = 1'b1; end
      ST_R4:   if (k_55) begin step_nx = ST_R5; cmd = 1'b1; end
      ST_R5:   if (k_20) begin cmd = 1'b1; arm_off = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pon_cnt <= NW'(PON_CYCLES);
      stb_q   <= 1'b0;
      hi_cnt  <= '0;
    end else begin
      if (!supply_ok)           pon_cnt <= NW'(PON_CYCLES);
      else if (pon_cnt != '0)   pon_cnt <= pon_cnt - 1'b1;
      stb_q <= wr_stb;
      if (!wr_stb)                       hi_cnt <= '0;
      else if (hi_cnt != PW'(MIN_PULSE)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_stb) begin
      addr_q <= wr_addr;
      data_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step     <= ST_IDLE;
      pend     <= PD_NONE;
      busy     <= 1'b0;
      win_act  <= 1'b0;
      win_cnt  <= '0;
      unlock   <= 1'b0;
      load_en  <= 1'b0;
      prog_req <= 1'b0;
    end else begin
      load_en  <= 1'b0;
      prog_req <= 1'b0;
      if (ev) begin
        step    <= step_nx;
        win_act <= 1'b1;
        win_cnt <= WW'(LOAD_WIN);
        if (arm_on)  begin unlock <= 1'b1; pend <= PD_ON;  end
        if (arm_off) begin unlock <= 1'b1; pend <= PD_OFF; end
        if (!cmd && (!wp_on || unlock)) load_en <= 1'b1;
      end else if (win_act) begin
        if (win_cnt == '0) begin
          prog_req <= 1'b1;
          win_act  <= 1'b0;
          busy     <= 1'b1;
          step     <= ST_IDLE;
          unlock   <= 1'b0;
        end else begin
          win_cnt <= win_cnt - 1'b1;
        end
      end
      if (busy && prog_done) begin
        busy <= 1'b0;
        pend <= PD_NONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ev) begin
      load_addr <= addr_q;
      load_data <= data_q;
    end
  end

  always_ff @(posedge clk) begin
    if (factory_init)
      wp_on <= 1'b0;
    else if (rst_n && busy && prog_done) begin
      if (pend == PD_ON)       wp_on <= 1'b1;
      else if (pend == PD_OFF) wp_on <= 1'b0;
    end
  end
endmodule

// File: rtl/wp_cmd_seq_chk.sv
module wp_cmd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic factory_init,
  input logic supply_ok,
  input logic prog_done,
  input logic wp_on,
  input logic load_en,
  input logic prog_req
);
  p_supply_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !load_en);

  p_wp_moves_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wp_on) |-> ($past(prog_done) || $past(factory_init)));

  p_prog_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);

  p_busy_no_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !load_en);

  p_load_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> !load_en);

  p_factory_clear_r12: assert property (@(posedge clk)
    factory_init |=> !wp_on);
endmodule

bind wp_cmd_seq wp_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .factory_init(factory_init), .supply_ok(supply_ok),
  .prog_done(prog_done), .wp_on(wp_on), .load_en(load_en), .prog_req(prog_req)
);

// File: tb/tb_wp_cmd_seq.sv
`timescale 1ns/1ps
module tb_wp_cmd_seq;
  localparam int AW = 17, DW = 8, MP = 3, LW = 12, PON = 24;

  logic clk = 0, rst_n = 0, factory_init = 1, supply_ok = 0, wr_stb = 0, prog_done = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wp_on, load_en, prog_req;
  logic [AW-1:0] load_addr;
  logic [DW-1:0] load_data;

  wp_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .MIN_PULSE(MP), .LOAD_WIN(LW), .PON_CYCLES(PON)) dut (
    .clk(clk), .rst_n(rst_n), .factory_init(factory_init), .supply_ok(supply_ok),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .prog_done(prog_done),
    .wp_on(wp_on), .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
    .prog_req(prog_req));

  always #2 clk = ~clk;

  int total = 0, bad = 0, n_load = 0, n_prog = 0;
  logic [AW-1:0] last_a;
  logic [DW-1:0] last_d;
  bit started = 0;

  // behavioural reference
  int m_hi, m_pon, m_step, m_win, m_pend;
  bit m_stbq, m_busy, m_winact, m_unlock, m_prot, m_load, m_prog;
  int m_aq, m_dq, m_la, m_ld;

  function automatic bit hit(int a, int d, int ea, int ed);
    return ((a & 32'h7FFF) == ea) && ((d & 32'hFF) == ed);
  endfunction

  always @(posedge clk) begin
    bit old_prot, old_busy, ev, cmd, on, off;
    int nstep;
    old_prot = m_prot;
    old_busy = m_busy;
    if (factory_init) m_prot = 0;
    else if (rst_n && old_busy && prog_done) begin
      if (m_pend == 1) m_prot = 1; else if (m_pend == 2) m_prot = 0;
    end
    if (!rst_n) begin
      m_pon = PON; m_stbq = 0; m_hi = 0; m_step = 0; m_pend = 0; m_busy = 0;
      m_winact = 0; m_win = 0; m_unlock = 0; m_load = 0; m_prog = 0;
    end else begin
      ev = m_stbq && !wr_stb && m_hi >= MP && supply_ok && m_pon == 0 && !old_busy;
      m_load = 0; m_prog = 0;
      if (ev) begin
        cmd = 0; on = 0; off = 0; nstep = 0;
        case (m_step)
          0: if (hit(m_aq, m_dq, 'h5555, 'hAA)) begin nstep = 1; cmd = 1; end
          1: if (hit(m_aq, m_dq, 'h2AAA, 'h55)) begin nstep = 2; cmd = 1; end
          2: if (hit(m_aq, m_dq, 'h5555, 'hA0)) begin cmd = 1; on = 1; end
             else if (hit(m_aq, m_dq, 'h5555, 'h80)) begin nstep = 3; cmd = 1; end
          3: if (hit(m_aq, m_dq, 'h5555, 'hAA)) begin nstep = 4; cmd = 1; end
          4: if (hit(m_aq, m_dq, 'h2AAA, 'h55)) begin nstep = 5; cmd = 1; end
          5: if (hit(m_aq, m_dq, 'h5555, 'h20)) begin cmd = 1; off = 1; end
          default: ;
        endcase
        if (!cmd && (!old_prot || m_unlock)) m_load = 1;
        m_la = m_aq; m_ld = m_dq;
        m_step = nstep; m_winact = 1; m_win = LW;
        if (on)  begin m_unlock = 1; m_pend = 1; end
        if (off) begin m_unlock = 1; m_pend = 2; end
      end else if (m_winact) begin
        if (m_win == 0) begin
          m_prog = 1; m_winact = 0; m_busy = 1; m_step = 0; m_unlock = 0;
        end else m_win--;
      end
      if (old_busy && prog_done) begin m_busy = 0; m_pend = 0; end
      if (wr_stb) begin
        m_aq = int'(wr_addr); m_dq = int'(wr_data);
        if (m_hi < MP) m_hi++;
      end else m_hi = 0;
      m_stbq = wr_stb;
      if (!supply_ok) m_pon = PON; else if (m_pon > 0) m_pon--;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk(wp_on === m_prot, "R5/R6/R12 model wp_on", int'(wp_on), int'(m_prot));
    chk(load_en === m_load, "R3/R4 model load_en", int'(load_en), int'(m_load));
    if (m_load) begin
      chk(int'(load_addr) == m_la, "R3 model load_addr", int'(load_addr), m_la);
      chk(int'(load_data) == m_ld, "R3 model load_data", int'(load_data), m_ld);
    end
    chk(prog_req === m_prog, "R7 model prog_req", int'(prog_req), int'(m_prog));
    if (load_en === 1'b1) begin n_load++; last_a = load_addr; last_d = load_data; end
    if (prog_req === 1'b1) n_prog++;
  end

  task automatic wr(int a, int d, int len = MP);
    @(negedge clk);
    wr_stb = 1; wr_addr = AW'(a); wr_data = DW'(d);
    repeat (len) @(negedge clk);
    wr_stb = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic period(string req, int exp_prog);
    int p0 = n_prog;
    repeat (LW + 4) @(negedge clk);
    chk(n_prog == p0 + exp_prog, req, n_prog - p0, exp_prog);
    prog_done = 1;
    @(negedge clk);
    prog_done = 0;
    @(negedge clk);
  endtask

  task automatic preamble();
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'hA0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int l0;
    repeat (3) @(negedge clk);
    started = 1;
    chk(wp_on == 0 && load_en == 0 && prog_req == 0, "R12 reset state", int'(wp_on), 0);
    factory_init = 0; rst_n = 1;
    @(negedge clk);
    // R8: supply low, then inside power-on delay
    l0 = n_load; wr('h00100, 'h11);
    chk(n_load == l0, "R8 write with supply low", n_load - l0, 0);
    supply_ok = 1;
    l0 = n_load; wr('h00101, 'h12);
    chk(n_load == l0, "R8 write during power-on delay", n_load - l0, 0);
    repeat (PON + 4) @(negedge clk);
    // R3 ordinary write unprotected
    l0 = n_load; wr('h01234, 'h5A);
    chk(n_load == l0 + 1, "R3 unprotected write loads", n_load - l0, 1);
    chk(last_a == 'h01234 && last_d == 'h5A, "R3 captured address", int'(last_a), 'h01234);
    period("R7 window expiry starts programming", 1);
    // R9 short pulse
    l0 = n_load; wr('h00200, 'h33, MP - 1);
    chk(n_load == l0, "R9 short pulse ignored", n_load - l0, 0);
    repeat (LW + 4) @(negedge clk);
    chk(n_prog == 2 - 1, "R9 no programming after short pulse", n_prog, 1);
    // R7 restart: two writes in one window
    wr('h00300, 'h01); repeat (6) @(negedge clk); wr('h00301, 'h02);
    period("R7 restart gives one request", 1);
    // R1 + R5 enable without data
    l0 = n_load; preamble();
    chk(n_load == l0, "R1 preamble not stored", n_load - l0, 0);
    repeat (LW + 4) @(negedge clk);
    chk(wp_on == 0, "R5 not protected before end of period", int'(wp_on), 0);
    prog_done = 1; @(negedge clk); prog_done = 0; @(negedge clk);
    chk(wp_on == 1, "R5 protected after period", int'(wp_on), 1);
    // R4 protected plain write
    l0 = n_load; wr('h00400, 'h44);
    chk(n_load == l0, "R4 protected write not stored", n_load - l0, 0);
    period("R4 protected write still programs", 1);
    // R1 protected write with preamble, then R10 busy write
    l0 = n_load; preamble(); wr('h00480, 'h66); wr('h00481, 'h67);
    chk(n_load == l0 + 2, "R1 preamble admits data", n_load - l0, 2);
    chk(last_a == 'h00481 && last_d == 'h67, "R1 admitted data", int'(last_d), 'h67);
    repeat (LW + 4) @(negedge clk);
    l0 = n_load; wr('h00490, 'h70);
    chk(n_load == l0, "R10 busy write ignored", n_load - l0, 0);
    prog_done = 1; @(negedge clk); prog_done = 0;
    l0 = n_prog; repeat (LW + 4) @(negedge clk);
    chk(n_prog == l0, "R10 busy write opened no window", n_prog - l0, 0);
    chk(wp_on == 1, "R5 preamble write keeps protection", int'(wp_on), 1);
    // R11 break while protected: plain write not stored
    l0 = n_load; wr('h5555, 'hAA); wr('h2AAA, 'h99); wr('h5555, 'hA0); wr('h00500, 'h01);
    chk(n_load == l0, "R11 broken preamble admits nothing", n_load - l0, 0);
    period("R11 broken preamble programs", 1);
    // R12 reset keeps protection
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
    chk(wp_on == 1, "R12 reset keeps protection", int'(wp_on), 1);
    repeat (PON + 4) @(negedge clk);
    // R2 + R6 release with one byte
    l0 = n_load;
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'h80);
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'h20);
    chk(n_load == l0, "R2 release bytes not stored", n_load - l0, 0);
    wr('h00600, 'hC3);
    chk(n_load == l0 + 1, "R6 data after release stored", n_load - l0, 1);
    repeat (LW + 4) @(negedge clk);
    chk(wp_on == 1, "R6 still protected before end", int'(wp_on), 1);
    prog_done = 1; @(negedge clk); prog_done = 0; @(negedge clk);
    chk(wp_on == 0, "R6 released after period", int'(wp_on), 0);
    // R11 break while unprotected: breaking write stored
    l0 = n_load; wr('h5555, 'hAA); wr('h2AAA, 'h99);
    chk(n_load == l0 + 1 && last_a == 'h2AAA, "R11 breaking write stored", n_load - l0, 1);
    period("R11 programming after break", 1);
    // R12 factory init
    preamble(); period("R5 second enable", 1);
    chk(wp_on == 1, "R5 protected again", int'(wp_on), 1);
    factory_init = 1; @(negedge clk); factory_init = 0; @(negedge clk);
    chk(wp_on == 0, "R12 factory init clears", int'(wp_on), 0);
    // R8 supply drop after running
    supply_ok = 0; l0 = n_load; wr('h00700, 'h77);
    chk(n_load == l0, "R8 supply drop blocks write", n_load - l0, 0);
    supply_ok = 1; repeat (PON + 4) @(negedge clk);
    l0 = n_load; wr('h00701, 'h78);
    chk(n_load == l0 + 1, "R8 write after delay", n_load - l0, 1);
    period("R7 final period", 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule